// File: doc/BRIEF.md
# Half-Step Clock Pre-Divider

This block divides a source clock by a ratio that steps in halves of a source period. A divider code of width `CODE_W` selects the ratio. The output spans `code + 1` source half-periods, so the output frequency is twice the source frequency divided by `code + 1`. An odd code therefore gives a whole-number ratio. An even code gives a ratio ending in .5, which needs events on both source edges. Codes 0 and 1 both pass the source clock through. The largest code, all ones, divides by 2^(CODE_W-1). The output drives a later fractional rate stage.

The design holds the ratio that is in force for one frame. A frame is two output periods, which is exactly `code + 1` whole source cycles, and it always begins on a rising source edge. A code presented on the input is taken only when a frame ends. Because of this, a change never cuts a pulse short.

Internally, a counter clocked on the rising edge prepares two levels. One is the level for the coming low half of the source clock. The other is the level for the next high half. A single flop clocked on the falling edge moves the second level into place. The output selects between these two levels with the source clock. Each flop changes only while its value is not the one selected.

Top module: `hdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_div` is low. It stays low through the first low source half-phase after release. The first output period then begins high at the next rising source edge, using the code present at that edge.
- R2: For codes 0 and 1, `clk_div` is high during every high source half-phase and low during every low one, so it copies the source clock.
- R3: For an odd code of 3 or more, the output period is (code+1)/2 source cycles. The output is high for exactly (code+1)/2 source half-periods and low for the same number.
- R4: For an even code of 2 or more, the output period is code+1 source half-periods. The output is high for code/2+1 of them and low for code/2 of them, so the two phases differ by one half-period.
- R5: Every rising edge of `clk_div` coincides with a source edge. For even codes of 2 or more, successive output rises alternate between rising and falling source edges. For all other codes they all fall on rising source edges.
- R6: A frame is two output periods (code+1 source cycles) and starts on a rising source edge. The code is sampled only at the rising source edge that starts a frame. A code change during a frame leaves the rest of that frame on the old ratio, and the next frame uses the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | CODE_W | Divider code; the ratio is (code+1)/2, and code 0 acts as 1 |
| clk_div | output | 1 | Divided clock |

## Verification
The hardest case to reach from the ports is a code change that lands inside a frame with an odd half-period count. In that case the first output period ends on a falling source edge, so the frame start cannot be seen from a single rising edge of the output. The bench samples the output in the middle of every source half-phase and treats the result as a bit stream. It finds a frame start as an output rise seen in a high source phase while a .5 ratio is active. It then changes the code one half-phase later and checks that the old pattern runs to the end of the frame before the new pattern begins. Every code from 0 to 31 is also swept, and each one's high/low half-period counts and rise alignment are compared with values computed from the code.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    localparam int DEF_CODE_W = 5;

    // Output level for half-period t of a frame of 2*h half-periods:
    // each period holds ceil(h/2) high halves followed by the low ones.
    function automatic logic half_level(input int unsigned t, input int unsigned h);
        int unsigned u;
        u = (t >= h) ? (t - h) : t;
        return (u < ((h + 1) / 2));
    endfunction

endpackage

// File: rtl/hdiv_sequencer.sv
module hdiv_sequencer #(
    parameter int CODE_W = hdiv_pkg::DEF_CODE_W
) (
    input  logic                clk_src,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   div_code,
    output logic [CODE_W:0]     cnt,
    output logic [CODE_W:0]     ratio,
    output logic                lo_level,
    output logic                next_hi_level
);
    localparam int HW = CODE_W + 1;

    typedef struct packed {
        logic [HW-1:0] cnt;     // source cycle within the frame
        logic [HW-1:0] ratio;   // half-periods per output period
        logic          lo;      // level for the current low half
        logic          nhi;     // level for the next high half
    } seq_t;

    seq_t st_d, st_q;

    logic [HW-1:0] eff_d;
    logic          wrap_d;
    int unsigned   t_lo_d, t_hi_d;

    always_comb begin
        st_d   = st_q;
        eff_d  = (div_code == '0) ? HW'(2) : (HW'(div_code) + HW'(1));
        wrap_d = (st_q.cnt == (st_q.ratio - HW'(1)));
        if (wrap_d) begin
            st_d.cnt   = '0;
            st_d.ratio = eff_d;
        end else begin
            st_d.cnt   = st_q.cnt + HW'(1);
        end
        t_lo_d = 2 * int'(st_d.cnt) + 1;
        t_hi_d = 2 * int'(st_d.cnt) + 2;
        if (t_hi_d == 2 * int'(st_d.ratio)) begin
            t_hi_d = 0;
        end
        st_d.lo  = hdiv_pkg::half_level(t_lo_d, int'(st_d.ratio));
        st_d.nhi = hdiv_pkg::half_level(t_hi_d, int'(st_d.ratio));
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.ratio <= HW'(1);
            st_q.lo    <= 1'b0;
            st_q.nhi   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt           = st_q.cnt;
    assign ratio         = st_q.ratio;
    assign lo_level      = st_q.lo;
    assign next_hi_level = st_q.nhi;

endmodule

// File: rtl/hdiv_edge_merge.sv
module hdiv_edge_merge (
    input  logic clk_src,
    input  logic rst_n,
    input  logic lo_level,
    input  logic next_hi_level,
    output logic clk_div
);
    logic hi_d, hi_q;

    always_comb begin
        hi_d = next_hi_level;
    end

    // Updated while the low half is on the output, so it is settled
    // before the high half selects it.
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
        end
    end

    assign clk_div = clk_src ? hi_q : lo_level;

endmodule

// File: rtl/hdiv_top.sv
module hdiv_top #(
    parameter int CODE_W = hdiv_pkg::DEF_CODE_W
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              clk_div
);
    logic [CODE_W:0] seq_cnt;
    logic [CODE_W:0] seq_ratio;
    logic            seq_lo;
    logic            seq_next_hi;

    hdiv_sequencer #(.CODE_W(CODE_W)) seq_i (
        .clk_src       (clk_src),
        .rst_n         (rst_n),
        .div_code      (div_code),
        .cnt           (seq_cnt),
        .ratio         (seq_ratio),
        .lo_level      (seq_lo),
        .next_hi_level (seq_next_hi)
    );

    hdiv_edge_merge merge_i (
        .clk_src       (clk_src),
        .rst_n         (rst_n),
        .lo_level      (seq_lo),
        .next_hi_level (seq_next_hi),
        .clk_div       (clk_div)
    );

endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
    parameter int CODE_W = hdiv_pkg::DEF_CODE_W
) (
    input logic              clk_src,
    input logic              rst_n,
    input logic [CODE_W-1:0] div_code,
    input logic [CODE_W:0]   cnt,
    input logic [CODE_W:0]   ratio,
    input logic              next_hi
);
    localparam int HW = CODE_W + 1;

    // R6
    frame_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cnt != (ratio - HW'(1))) |=> $stable(ratio));

    // R6
    cnt_range_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        cnt < ratio);

    // R2
    ratio_floor_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cnt != '0) |-> (ratio >= HW'(2)));

    // R5
    frame_start_high_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (cnt == (ratio - HW'(1))) |-> next_hi);

    // R3
    ratio_follows_code_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        ((cnt == (ratio - HW'(1))) && (div_code != '0)) |=> (ratio == HW'($past(div_code)) + HW'(1)));

endmodule

bind hdiv_top hdiv_checker #(.CODE_W(CODE_W)) chk_i (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .div_code (div_code),
    .cnt      (seq_cnt),
    .ratio    (seq_ratio),
    .next_hi  (seq_next_hi)
);

// File: tb/hdiv_top_tb_top.sv
module hdiv_top_tb_top;
    localparam int CW = 5;

    logic          clk_src = 1'b0;
    logic          rst_n   = 1'b0;
    logic [CW-1:0] div_code = CW'(4);
    logic          clk_div;

    int checks   = 0;
    int failures = 0;

    hdiv_top #(.CODE_W(CW)) dut_i (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .div_code (div_code),
        .clk_div  (clk_div)
    );

    always #5 clk_src = ~clk_src;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sample the output mid-way through the next source half-phase.
    task automatic next_half(output bit v, output bit ph);
        @(clk_src);
        #2;
        v  = clk_div;
        ph = clk_src;
    endtask

    function automatic int ratio_of(input int code);
        return (code == 0) ? 2 : code + 1;
    endfunction

    function automatic bit exp_level(input int j, input int h);
        return ((j % h) < ((h + 1) / 2));
    endfunction

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit v, ph, prev, found;
        int mism, first_j, h, rise_ph, mid_ph;
        string tag;

        // R1: low during reset
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            next_half(v, ph);
            if (v) mism++;
        end
        chk(mism == 0, "R1", "high samples in reset", mism, 0);

        @(posedge clk_src);
        #2;
        rst_n = 1'b1;
        next_half(v, ph);
        chk(v == 1'b0, "R1", "low half after release", int'(v), 0);
        // code 4 -> five half-periods per period
        mism = 0;
        for (int j = 0; j < 20; j++) begin
            next_half(v, ph);
            if (v != exp_level(j, 5)) mism++;
        end
        chk(mism == 0, "R1", "first periods after release (R4 pattern)", mism, 0);

        // Sweep every code
        for (int k = 0; k < (1 << CW); k++) begin
            div_code = CW'(k);
            h = ratio_of(k);
            tag = (k <= 1) ? "R2" : ((k % 2) == 1) ? "R3" : "R4";
            for (int s = 0; s < 140; s++) next_half(v, ph);
            prev = 1'b1;
            found = 1'b0;
            rise_ph = 0;
            for (int s = 0; s < 80 && !found; s++) begin
                next_half(v, ph);
                if (!prev && v) begin
                    found = 1'b1;
                    rise_ph = int'(ph);
                end
                prev = v;
            end
            chk(found, tag, "output rise found", int'(found), 1);
            mism = 0;
            first_j = -1;
            mid_ph = 0;
            for (int j = 1; j < 4 * h; j++) begin
                next_half(v, ph);
                if (j == h) mid_ph = int'(ph);
                if (v != exp_level(j, h)) begin
                    mism++;
                    if (first_j < 0) first_j = j;
                end
            end
            if (mism != 0)
                $display("  code=%0d first mismatch at half %0d", k, first_j);
            chk(mism == 0, tag, $sformatf("pattern mismatches code=%0d", k), mism, 0);
            chk((mid_ph != rise_ph) == ((h % 2) == 1), "R5",
                $sformatf("rise edge alternation code=%0d", k),
                int'(mid_ph != rise_ph), int'((h % 2) == 1));
        end

        // R6: mid-frame change is deferred to the frame end
        div_code = CW'(8);
        for (int s = 0; s < 140; s++) next_half(v, ph);
        prev = 1'b1;
        found = 1'b0;
        for (int s = 0; s < 80 && !found; s++) begin
            next_half(v, ph);
            if (!prev && v && ph) found = 1'b1;
            prev = v;
        end
        chk(found, "R6", "frame start located", int'(found), 1);
        div_code = CW'(4);
        mism = 0;
        for (int j = 1; j < 18; j++) begin
            next_half(v, ph);
            if (v != exp_level(j, 9)) mism++;
        end
        chk(mism == 0, "R6", "old ratio holds to frame end", mism, 0);
        mism = 0;
        for (int j = 0; j < 20; j++) begin
            next_half(v, ph);
            if (v != exp_level(j, 5)) mism++;
        end
        chk(mism == 0, "R6", "new ratio from next frame", mism, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule